// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one read or write command of a synchronous DRAM controller into the column addresses of its burst. The controller pulses a start strobe with the first column, a 3-bit burst-length code and an ordering bit. From the next clock on, the block presents one column address per cycle. It flags the final beat of a fixed-length burst and pulses a done output once the burst is over.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block of columns. In linear ordering the low bits count up and wrap inside the block. In the alternative ordering the low bits are the start bits XOR the beat number. A page-length code instead walks the whole row upward, wraps from the top column to column 0, and keeps going until an abort or a new command stops it. An abort input lets the next command cut any burst short. Start codes that name no length are refused and flagged.

Top module: `burst_col_seq`

## Requirements
- R1: Length codes select the beat count: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. The first beat appears in the cycle after the start strobe is sampled, and then one beat follows per cycle.
- R2: A start with code 3'b100, 3'b101 or 3'b110 starts no burst and sets `cfg_err_o` from the next cycle. The flag holds until a start with any other code is accepted, which clears it.
- R3: With `wrap_i` = 0 on a fixed burst, the low log2(length) column bits begin at the start value, add one per beat and wrap inside the aligned block (start 1, length 4 gives 1,2,3,0).
- R4: With `wrap_i` = 1 on a fixed burst, the low log2(length) bits of beat k equal the start's low bits XOR k (start 5, length 8 gives 5,4,7,6,1,0,3,2).
- R5: A length-1 burst presents only the start column, with either value of `wrap_i`.
- R6: Code 3'b111 runs a page burst. The whole column adds one per beat and wraps from the top column to 0, `wrap_i` has no effect, and the burst runs until aborted or restarted.
- R7: Column bits above the length window keep the start value for the whole of a fixed burst.
- R8: An abort sampled during a burst ends it at that edge, and `done_o` pulses in the next cycle. `col_valid_o` is low while abort is high. An abort while idle has no effect.
- R9: `last_o` is high exactly on the final beat of a fixed burst and never during a page burst.
- R10: `done_o` is a one-cycle pulse in the cycle after the final beat of a fixed burst.
- R11: A valid start during a burst restarts at beat 0 with the new column and code, and gives no done pulse for the burst it replaces.
- R12: During and straight after reset, `col_valid_o`, `last_o`, `done_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | First column of the burst |
| blen_code_i | input | 3 | Burst-length code |
| wrap_i | input | 1 | Ordering: 0 linear, 1 XOR |
| abort_i | input | 1 | Ends the current burst |
| col_valid_o | output | 1 | A beat is presented on `col_o` |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Final beat of a fixed burst |
| done_o | output | 1 | Pulse after a burst has ended |
| cfg_err_o | output | 1 | Last start carried a reserved code |

## Verification
The assertions assume that start, abort and the command fields are only meaningful at rising edges, and that a beat lasts exactly one cycle. The upper-bit check assumes at least four column bits. The bench changes every input just after a falling edge and holds it for a full cycle. It raises abort only on a beat it has already counted, or once on purpose while idle. Reserved codes are applied only while idle, so every expected beat comes from one command at a time.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int SPAN_LOG2_W = 4;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef enum logic [2:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_RSV4 = 3'b100,
        BLEN_RSV5 = 3'b101,
        BLEN_RSV6 = 3'b110,
        BLEN_PAGE = 3'b111
    } blen_code_e;

    typedef struct packed {
        logic                   reserved;
        logic                   full_page;
        order_e                 order;
        logic [SPAN_LOG2_W-1:0] span_log2;
    } burst_cfg_t;

    // Map a length code and ordering bit onto the burst description.
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code,
                                              input logic       wrap_bit);
        burst_cfg_t c;
        c.reserved  = 1'b0;
        c.full_page = 1'b0;
        c.order     = order_e'(wrap_bit);
        c.span_log2 = '0;
        case (blen_code_e'(code))
            BLEN_1:    c.span_log2 = SPAN_LOG2_W'(0);
            BLEN_2:    c.span_log2 = SPAN_LOG2_W'(1);
            BLEN_4:    c.span_log2 = SPAN_LOG2_W'(2);
            BLEN_8:    c.span_log2 = SPAN_LOG2_W'(3);
            BLEN_PAGE: begin
                c.full_page = 1'b1;
                c.order     = ORDER_LINEAR;
            end
            default:   c.reserved = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import burst_seq_pkg::*;
(
    input  logic [2:0]  code_i,
    input  logic        wrap_i,
    output burst_cfg_t  cfg_o
);

    always_comb begin
        cfg_o = decode_cfg(code_i, wrap_i);
    end

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] win_mask;
    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_val;

    // Bits inside the burst window follow the beat; the rest hold the base.
    always_comb begin
        for (int i = 0; i < COL_W; i++) begin
            win_mask[i] = cfg_i.full_page || (i < int'(cfg_i.span_log2));
        end
    end

    assign lin_sum = base_i + beat_i;
    assign xor_val = base_i ^ beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = win_mask[i]
                        ? ((cfg_i.order == ORDER_XOR) ? xor_val[i] : lin_sum[i])
                        : base_i[i];
    end

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [COL_W-1:0] col_in_i,
    input  burst_cfg_t       cfg_in_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output burst_cfg_t       cfg_o,
    output logic             at_last_o,
    output logic             done_o,
    output logic             cfg_err_o
);

    logic             active_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic             done_q;
    logic             err_q;
    logic [COL_W-1:0] last_idx;
    logic             load;

    assign load      = start_i && !cfg_in_i.reserved;
    assign last_idx  = (COL_W'(1) << cfg_q.span_log2) - COL_W'(1);
    assign at_last_o = active_q && !cfg_q.full_page && (beat_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            base_q   <= '0;
            cfg_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                active_q <= 1'b1;
                beat_q   <= '0;
                base_q   <= col_in_i;
                cfg_q    <= cfg_in_i;
                err_q    <= 1'b0;
            end else begin
                if (start_i) begin
                    err_q <= 1'b1;
                end
                if (active_q) begin
                    if (abort_i || at_last_o) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        beat_q <= beat_q + COL_W'(1);
                    end
                end
            end
        end
    end

    assign active_o  = active_q;
    assign beat_o    = beat_q;
    assign base_o    = base_q;
    assign cfg_o     = cfg_q;
    assign done_o    = done_q;
    assign cfg_err_o = err_q;

    // R8: an abort during a burst yields a done pulse next cycle
    a_r8_abort_done: assert property (@(posedge clk) disable iff (rst)
        active_q && abort_i && !start_i |=> done_q && !active_q);

    // R10: done is never longer than one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R2: a reserved code raises the error flag
    a_r2_reserved_flag: assert property (@(posedge clk) disable iff (rst)
        start_i && cfg_in_i.reserved |=> err_q);

    // R11: an accepted start always restarts at beat 0
    a_r11_restart_zero: assert property (@(posedge clk) disable iff (rst)
        load |=> active_q && (beat_q == '0) && !done_q);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_code_i,
    input  logic             wrap_i,
    input  logic             abort_i,
    output logic             col_valid_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o,
    output logic             done_o,
    output logic             cfg_err_o
);

    burst_cfg_t       cfg_dec;
    burst_cfg_t       cfg_run;
    logic             active;
    logic             at_last;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;

    bseq_decode u_decode (
        .code_i (blen_code_i),
        .wrap_i (wrap_i),
        .cfg_o  (cfg_dec)
    );

    bseq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .abort_i   (abort_i),
        .col_in_i  (start_col_i),
        .cfg_in_i  (cfg_dec),
        .active_o  (active),
        .beat_o    (beat),
        .base_o    (base),
        .cfg_o     (cfg_run),
        .at_last_o (at_last),
        .done_o    (done_o),
        .cfg_err_o (cfg_err_o)
    );

    bseq_addr #(.COL_W(COL_W)) u_addr (
        .base_i (base),
        .beat_i (beat),
        .cfg_i  (cfg_run),
        .col_o  (col_o)
    );

    assign col_valid_o = active && !abort_i;
    assign last_o      = at_last && !abort_i;

    // R9: page bursts never flag a last beat
    a_r9_no_last_page: assert property (@(posedge clk) disable iff (rst)
        active && cfg_run.full_page |-> !last_o);

    // R6: page bursts step the whole column by one
    a_r6_page_step: assert property (@(posedge clk) disable iff (rst)
        col_valid_o && cfg_run.full_page && $past(col_valid_o) && !$past(start_i)
        |-> col_o == $past(col_o) + COL_W'(1));

    // R4: XOR ordering leaves column XOR start equal to the beat number
    a_r4_xor_beat: assert property (@(posedge clk) disable iff (rst)
        col_valid_o && !cfg_run.full_page && (cfg_run.order == ORDER_XOR)
        |-> (col_o ^ base) == beat);

    // R7: bits above an 8-beat window never move inside a fixed burst
    a_r7_upper_hold: assert property (@(posedge clk) disable iff (rst)
        col_valid_o && !cfg_run.full_page && $past(col_valid_o) && !$past(start_i)
        |-> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

endmodule

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/100ps
module tb_burst_col_seq;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_code_i = '0;
    logic             wrap_i = 1'b0;
    logic             abort_i = 1'b0;
    logic             col_valid_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;
    logic             done_o;
    logic             cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit               is_done;
        logic [COL_W-1:0] col;
        bit               last;
        string            tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_code_i (blen_code_i),
        .wrap_i      (wrap_i),
        .abort_i     (abort_i),
        .col_valid_o (col_valid_o),
        .col_o       (col_o),
        .last_o      (last_o),
        .done_o      (done_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        return (code == 3'b111) ? 0 : (1 << code);
    endfunction

    // Expected column of beat k, written from the ordering rules.
    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input logic [2:0] code, input bit wrap, input int k);
        int m, lo;
        if (code == 3'b111) return COL_W'((int'(s) + k) % 256);
        m  = (1 << code) - 1;
        lo = wrap ? ((int'(s) & m) ^ k) : (((int'(s) & m) + k) & m);
        return COL_W'((int'(s) & ~m) | lo);
    endfunction

    function automatic void push_beats(input logic [COL_W-1:0] s,
            input logic [2:0] code, input bit wrap, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.is_done = 0;
            e.col     = exp_col(s, code, wrap, k);
            e.last    = (code != 3'b111) && (k == beats_of(code) - 1);
            e.tag     = tag;
            exp_q.push_back(e);
        end
    endfunction

    function automatic void push_done(input string tag);
        exp_t e;
        e.is_done = 1;
        e.col     = '0;
        e.last    = 0;
        e.tag     = tag;
        exp_q.push_back(e);
    endfunction

    task automatic drive_start(input logic [COL_W-1:0] s, input logic [2:0] code,
                               input bit wrap);
        start_i     = 1'b1;
        start_col_i = s;
        blen_code_i = code;
        wrap_i      = wrap;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 600) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_burst(input logic [COL_W-1:0] s, input logic [2:0] code,
                             input bit wrap, input string tag);
        push_beats(s, code, wrap, beats_of(code), tag);
        push_done(tag);
        @(negedge clk);
        drive_start(s, code, wrap);
        @(negedge clk);
        start_i = 1'b0;
        drain();
    endtask

    task automatic run_abort(input logic [COL_W-1:0] s, input logic [2:0] code,
                             input bit wrap, input int n, input string tag);
        push_beats(s, code, wrap, n, tag);
        push_done(tag);
        @(negedge clk);
        drive_start(s, code, wrap);
        @(negedge clk);
        start_i = 1'b0;
        repeat (n - 1) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        drain();
    endtask

    // Monitor: pops one expected item for every beat or done it sees.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && (col_valid_o || done_o)) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected output", {col_valid_o, done_o}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_done) begin
                        check(done_o && !col_valid_o, e.tag, "done pulse",
                              {col_valid_o, done_o}, 1);
                    end else begin
                        check(col_valid_o && !done_o, e.tag, "beat valid",
                              {col_valid_o, done_o}, 2);
                        check(col_o == e.col, e.tag, "column", col_o, e.col);
                        check(last_o == e.last, e.tag, "last flag", last_o, e.last);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!col_valid_o && !last_o && !done_o && !cfg_err_o, "R12", "reset outputs",
              {col_valid_o, last_o, done_o, cfg_err_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!col_valid_o && !last_o && !done_o && !cfg_err_o, "R12", "after reset",
              {col_valid_o, last_o, done_o, cfg_err_o}, 0);

        // R1/R3: linear ordering over each length
        run_burst(8'h01, 3'b010, 1'b0, "R3");
        run_burst(8'h11, 3'b001, 1'b0, "R1");
        run_burst(8'hA5, 3'b011, 1'b0, "R7");
        // R4: XOR ordering
        run_burst(8'h01, 3'b010, 1'b1, "R4");
        run_burst(8'h5D, 3'b011, 1'b1, "R4");
        run_burst(8'h11, 3'b001, 1'b1, "R4");
        // R5: single beat with both orderings
        run_burst(8'h37, 3'b000, 1'b0, "R5");
        run_burst(8'h37, 3'b000, 1'b1, "R5");
        // R10: back-to-back checks of done are made by the monitor above

        // R6/R9: page burst wraps past the top column, wrap bit ignored
        run_abort(8'hFA, 3'b111, 1'b1, 10, "R6");
        // R8: abort mid fixed burst
        run_abort(8'h20, 3'b011, 1'b0, 3, "R8");

        // R8: abort while idle changes nothing
        @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        @(negedge clk);
        check(!col_valid_o && !done_o, "R8", "idle abort ignored",
              {col_valid_o, done_o}, 0);

        // R11: restart after two beats of an 8-beat burst
        push_beats(8'h40, 3'b011, 1'b0, 2, "R11");
        push_beats(8'h83, 3'b010, 1'b1, 4, "R11");
        push_done("R11");
        @(negedge clk);
        drive_start(8'h40, 3'b011, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        drive_start(8'h83, 3'b010, 1'b1);
        @(negedge clk);
        start_i = 1'b0;
        drain();

        // R2: reserved codes are refused and flagged until a good start
        for (int c = 4; c < 7; c++) begin
            @(negedge clk);
            drive_start(8'h10, 3'(c), 1'b0);
            @(negedge clk);
            start_i = 1'b0;
            check(cfg_err_o && !col_valid_o, "R2", "reserved code flagged",
                  {cfg_err_o, col_valid_o}, 2);
            @(negedge clk);
            check(cfg_err_o && !col_valid_o && !done_o, "R2", "flag held, no burst",
                  {cfg_err_o, col_valid_o, done_o}, 4);
        end
        push_beats(8'h06, 3'b001, 1'b0, 2, "R2");
        push_done("R2");
        @(negedge clk);
        drive_start(8'h06, 3'b001, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        check(!cfg_err_o, "R2", "flag cleared by good start", cfg_err_o, 0);
        drain();

        check(exp_q.size() == 0, "R1", "all expected beats seen", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule